// File: doc/BRIEF.md
# Audio Sample FIFO DMA Engine

This engine carries audio samples between converter-side streams and two circular FIFOs kept in storage that a processor also reaches. Each accepted input frame holds one or two channel samples and is written into the input FIFO. Each output request takes one frame out of the output FIFO and presents it on one or two output sample buses. A channel-layout mode sets where samples land. The layout can be consecutive, interleaved, or split so that each channel has its own half of the FIFO.

The processor reads the input FIFO and writes the output FIFO through one port, using either of two address views. The direct view uses physical locations, so the newest completed block moves through the FIFO as blocks arrive. The anchored view adds the base of the newest completed block to the processor's address, so offset 0 always reaches that block. A one-cycle interrupt marks each completed input block. A low-battery flag forces the output buses to zero. A read of the output FIFO before any block exists returns zero and sets a sticky flag.

Top module: `audio_fifo_dma`

## Requirements
- R1: Mode 0 (mono): input frame k is written to input location k. Output frame k is read from output location k onto `out_a`, and `out_b` is 0.
- R2: Mode 1 (single-out stereo): frame k writes `in_a` to location 2k and `in_b` to location 2k+1. Output frame k reads location k mod (DEPTH/2) onto `out_a`, and `out_b` is 0.
- R3: Mode 2 (split halves): frame k writes `in_a` to location k mod (DEPTH/2) and `in_b` to location DEPTH/2 + (k mod DEPTH/2). Output is read from the lower half, as in R2.
- R4: Mode 3 (full stereo): input is interleaved, as in R2. Output frame k reads location 2k onto `out_a` and location 2k+1 onto `out_b`.
- R5: `blk_irq` is high for exactly the one cycle after every frame whose index within its block is BLK-1. With `p_view`=0, `p_addr` is the physical location.
- R6: With `p_view`=1, the address is p_addr + base, where base is the newest completed block's first location for that FIFO's layout. The sum wraps modulo DEPTH. In split layouts (R3 input; R2/R3 output) only the low half-index wraps and the top address bit is kept.
- R7: While `batt_low` is 1, an output request drives both output buses to 0, and the output pointer still advances.
- R8: An output request made before any block has completed drives 0 and sets `underrun`. The flag stays set until `p_ur_clr` is asserted. A new underrun in the same cycle as a clear leaves it set.
- R9: `mode_in` is taken only while `run` is 0. A new value clears all pointers and the block state, and reloading the same value clears nothing. Streams are ignored while `run` is 0.
- R10: Write and read pointers wrap modulo the FIFO's region size, so mono frame DEPTH+k overwrites location k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Engine active; 0 = idle, mode may load |
| mode_in | input | 2 | Layout: 0 mono, 1 single-out stereo, 2 split halves, 3 full stereo |
| in_valid | input | 1 | Input frame present |
| in_a | input | DW | Input channel A sample |
| in_b | input | DW | Input channel B sample |
| out_req | input | 1 | Output frame request |
| batt_low | input | 1 | Low-battery mute |
| out_a | output | DW | Output channel A sample |
| out_b | output | DW | Output channel B sample |
| blk_irq | output | 1 | Block-ready pulse |
| p_addr | input | AW | Processor address |
| p_view | input | 1 | 0 direct view, 1 anchored view |
| p_rdata | output | DW | Input FIFO read data |
| p_we | input | 1 | Output FIFO write enable |
| p_wdata | input | DW | Output FIFO write data |
| p_ur_clr | input | 1 | Clear underrun (write 1) |
| underrun | output | 1 | Sticky underrun flag |

## Verification
Two events can land in the same cycle: the processor clearing the underrun flag, and an output request that finds no completed block. The bench raises `out_req` and `p_ur_clr` on the same clock edge, before any block exists. It then expects `underrun` to still read 1 and the output to be 0. A lone clear afterwards must bring the flag down.

// File: rtl/audio_fifo_dma.sv
module audio_fifo_dma #(
  parameter int DW = 16,
  parameter int AW = 5,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [1:0]    mode_in,
  input  logic          in_valid,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic          out_req,
  input  logic          batt_low,
  output logic [DW-1:0] out_a,
  output logic [DW-1:0] out_b,
  output logic          blk_irq,
  input  logic [AW-1:0] p_addr,
  input  logic          p_view,
  output logic [DW-1:0] p_rdata,
  input  logic          p_we,
  input  logic [DW-1:0] p_wdata,
  input  logic          p_ur_clr,
  output logic          underrun
);
  localparam int DEPTH = 1 << AW;
  localparam int HW = AW - 1;
  localparam logic [1:0] M_MONO = 2'd0, M_SS = 2'd1, M_MIX = 2'd2, M_FULL = 2'd3;

  logic [DW-1:0] imem [DEPTH];
  logic [DW-1:0] omem [DEPTH];
  logic [1:0]    mode_q;
  logic [AW-1:0] wp, rp, bf;
  logic          have_blk;

  function automatic logic [AW-1:0] remap(input logic [AW-1:0] p, input logic [AW-1:0] b,
                                          input logic split);
    logic [AW-1:0] s;
    s = p + b;
    return split ? {p[AW-1], s[HW-1:0]} : s;
  endfunction

  wire mono = (mode_q == M_MONO);
  wire mix  = (mode_q == M_MIX);
  wire full = (mode_q == M_FULL);

  wire [AW-1:0] wa = mono ? wp : mix ? {1'b0, wp[HW-1:0]} : {wp[HW-1:0], 1'b0};
  wire [AW-1:0] wb = mix ? {1'b1, wp[HW-1:0]} : {wp[HW-1:0], 1'b1};
  wire [AW-1:0] ra = mono ? rp : full ? {rp[HW-1:0], 1'b0} : {1'b0, rp[HW-1:0]};
  wire [AW-1:0] rb = {rp[HW-1:0], 1'b1};

  wire [AW-1:0] ibase = mono ? bf : mix ? {1'b0, bf[HW-1:0]} : {bf[HW-1:0], 1'b0};
  wire [AW-1:0] obase = mono ? bf : full ? {bf[HW-1:0], 1'b0} : {1'b0, bf[HW-1:0]};
  wire          osplit = (mode_q == M_SS) || mix;

  wire [AW-1:0] iaddr = p_view ? remap(p_addr, ibase, mix) : p_addr;
  wire [AW-1:0] oaddr = p_view ? remap(p_addr, obase, osplit) : p_addr;
  assign p_rdata = imem[iaddr];

  wire go_in   = run && in_valid;
  wire go_out  = run && out_req;
  wire blk_end = go_in && (wp[BW-1:0] == {BW{1'b1}});
  wire reload  = !run && (mode_in != mode_q);

  always_ff @(posedge clk) begin
    if (go_in) begin
      imem[wa] <= in_a;
      if (!mono) imem[wb] <= in_b;
    end
    if (p_we) omem[oaddr] <= p_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_MONO;
      wp       <= '0;
      rp       <= '0;
      bf       <= '0;
      have_blk <= 1'b0;
      blk_irq  <= 1'b0;
      underrun <= 1'b0;
      out_a    <= '0;
      out_b    <= '0;
    end else begin
      blk_irq <= blk_end;
      if (reload) begin
        mode_q   <= mode_in;
        wp       <= '0;
        rp       <= '0;
        bf       <= '0;
        have_blk <= 1'b0;
      end else begin
        if (go_in) wp <= wp + 1'b1;
        if (blk_end) begin
          bf       <= {wp[AW-1:BW], {BW{1'b0}}};
          have_blk <= 1'b1;
        end
        if (go_out) begin
          rp <= rp + 1'b1;
          if (!have_blk || batt_low) begin
            out_a <= '0;
            out_b <= '0;
          end else begin
            out_a <= omem[ra];
            out_b <= full ? omem[rb] : '0;
          end
        end
      end
      if (go_out && !have_blk) underrun <= 1'b1;
      else if (p_ur_clr)       underrun <= 1'b0;
    end
  end

  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_irq |=> !blk_irq);
  assert_mute_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go_out && batt_low) |=> (out_a == '0 && out_b == '0));
  assert_nodata_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go_out && !have_blk) |=> (underrun && out_a == '0));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !p_ur_clr) |=> underrun);
  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(mode_q));
endmodule

// File: tb/audio_fifo_dma_tb.sv
module audio_fifo_dma_tb;
  localparam int DW = 16, AW = 5, BW = 2;
  logic clk = 0, rst_n = 0, run = 0, in_valid = 0, out_req = 0, batt_low = 0;
  logic p_view = 0, p_we = 0, p_ur_clr = 0;
  logic [1:0] mode_in = 0;
  logic [DW-1:0] in_a = 0, in_b = 0, p_wdata = 0;
  logic [AW-1:0] p_addr = 0;
  logic [DW-1:0] out_a, out_b, p_rdata;
  logic blk_irq, underrun;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  audio_fifo_dma #(.DW(DW), .AW(AW), .BW(BW)) u_dut (
    .clk, .rst_n, .run, .mode_in, .in_valid, .in_a, .in_b, .out_req, .batt_low,
    .out_a, .out_b, .blk_irq, .p_addr, .p_view, .p_rdata, .p_we, .p_wdata,
    .p_ur_clr, .underrun);

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk); run = 0; mode_in = m;
    @(negedge clk); run = 1;
  endtask

  task automatic push(logic [DW-1:0] a, logic [DW-1:0] b, output logic irq);
    @(negedge clk); in_valid = 1; in_a = a; in_b = b;
    @(negedge clk); in_valid = 0; irq = blk_irq;
  endtask

  task automatic pull();
    @(negedge clk); out_req = 1;
    @(negedge clk); out_req = 0;
  endtask

  task automatic rd(logic view, logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); p_view = view; p_addr = a; #1 d = p_rdata;
  endtask

  task automatic wr(logic view, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); p_we = 1; p_view = view; p_addr = a; p_wdata = d;
    @(negedge clk); p_we = 0;
  endtask

  task automatic t_reset();
    chk("R8 reset underrun", underrun, 0);
    chk("R5 reset irq", blk_irq, 0);
    chk("R1 reset out", out_a, 0);
  endtask

  task automatic t_underrun();
    set_mode(0);
    pull();
    chk("R8 underrun set", underrun, 1);
    chk("R8 zero out", out_a, 0);
    @(negedge clk); out_req = 1; p_ur_clr = 1;
    @(negedge clk); out_req = 0; p_ur_clr = 0;
    chk("R8 set wins over clear", underrun, 1);
    @(negedge clk); p_ur_clr = 1;
    @(negedge clk); p_ur_clr = 0;
    chk("R8 cleared", underrun, 0);
  endtask

  task automatic t_ss();
    logic irq; logic [DW-1:0] d;
    set_mode(1);
    for (int k = 0; k < 4; k++) begin
      push(16'h100 + k, 16'h200 + k, irq);
      chk("R5 irq pulse", irq, k == 3);
    end
    @(negedge clk); chk("R5 irq one cycle", blk_irq, 0);
    for (int k = 0; k < 4; k++) begin
      rd(0, 2 * k, d);     chk("R2 interleave a", d, 16'h100 + k);
      rd(0, 2 * k + 1, d); chk("R2 interleave b", d, 16'h200 + k);
    end
    for (int k = 0; k < 4; k++) wr(0, k, 16'h300 + k);
    for (int k = 0; k < 2; k++) begin
      pull();
      chk("R2 out a", out_a, 16'h300 + k);
      chk("R2 out b zero", out_b, 0);
    end
  endtask

  task automatic t_mix();
    logic irq; logic [DW-1:0] d;
    set_mode(2);
    for (int k = 0; k < 8; k++) push(16'h400 + k, 16'h500 + k, irq);
    rd(0, 3, d);  chk("R3 lower half a", d, 16'h403);
    rd(0, 19, d); chk("R3 upper half b", d, 16'h503);
    rd(1, 0, d);  chk("R6 anchored a", d, 16'h404);
    rd(1, 16, d); chk("R6 anchored b", d, 16'h504);
    rd(1, 13, d); chk("R6 half wrap", d, 16'h401);
    wr(1, 0, 16'h600);
    for (int k = 0; k < 5; k++) pull();
    chk("R3 out lower half via anchor", out_a, 16'h600);
  endtask

  task automatic t_full();
    logic irq; logic [DW-1:0] d;
    set_mode(3);
    for (int k = 0; k < 4; k++) push(16'h0a0 + k, 16'h0b0 + k, irq);
    rd(0, 5, d); chk("R4 in interleave", d, 16'h0b2);
    for (int k = 0; k < 8; k++) wr(0, k, 16'h700 + k);
    for (int k = 0; k < 2; k++) begin
      pull();
      chk("R4 out a", out_a, 16'h700 + 2 * k);
      chk("R4 out b", out_b, 16'h701 + 2 * k);
    end
    batt_low = 1;
    pull();
    chk("R7 mute a", out_a, 0);
    chk("R7 mute b", out_b, 0);
    batt_low = 0;
    pull();
    chk("R7 pointer advanced a", out_a, 16'h706);
    chk("R7 pointer advanced b", out_b, 16'h707);
  endtask

  task automatic t_mono();
    logic irq; logic [DW-1:0] d; int n;
    set_mode(0);
    mode_in = 3;
    n = 0;
    for (int k = 0; k < 36; k++) begin
      push(16'h800 + k, 16'hffff, irq);
      n += irq;
    end
    chk("R5 block count", n, 9);
    rd(0, 1, d);  chk("R9 mode ignored while running", d, 16'h821);
    rd(0, 4, d);  chk("R1 consecutive", d, 16'h804);
    rd(0, 0, d);  chk("R10 wrap", d, 16'h820);
    rd(1, 5, d);  chk("R6 anchored mono", d, 16'h805);
    set_mode(0);
    push(16'h900, 0, irq);
    rd(0, 4, d);  chk("R9 same mode keeps pointer", d, 16'h900);
    wr(0, 0, 16'h9a0);
    pull();
    chk("R1 out mono", out_a, 16'h9a0);
    chk("R1 out b zero", out_b, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_underrun();
    t_ss();
    t_mix();
    t_full();
    t_mono();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule